// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a software-visible command register and a byte-level I2C bit engine. Software first loads an 8-bit data buffer, then writes one command word. The word can ask for any mix of five phases: start (send an address), transmit a byte, receive a byte, receive a final byte, and stop. The sequencer runs the requested phases one after another, always as start, then transmit, then receive, then stop. For each phase it hands one operation to the bit engine and waits for the engine to report completion. Each command bit drops once its phase has finished, and the remaining bits can be read on `pend_q`.

A readable 4-bit state field follows the transaction. Bit 3 of the field is the "bus owned" flag. The field decides whether a start is a fresh start or a repeated start, and whether a stop is legal. A stop requested while the flag is clear is not driven onto the bus; it raises the abnormal interrupt instead. A 4-bit interrupt status register collects the results of the phases. It is cleared by every accepted command write.

The control FSM has these states: `SEQ_IDLE` (waits for a command), `SEQ_PICK` (selects the highest-priority pending phase, or returns to idle when none is left), `SEQ_WAIT_ADDR`, `SEQ_WAIT_TX`, `SEQ_WAIT_RX` and `SEQ_WAIT_STOP` (each waits for the engine's done pulse). Its transitions are:
- IDLE→PICK on a command write.
- PICK→WAIT_x when an engine operation is issued.
- PICK→PICK when an illegal stop is absorbed.
- PICK→IDLE when nothing is pending.
- WAIT_x→PICK on done.

Top module: `i2c_cmd_sequencer`

## Requirements
- R1: A command write while `busy` is low clears `irq_q` to 0, loads `cmd_bits` into `pend_q` and raises `busy` on the next cycle. `busy` stays high until every requested phase has completed.
- R2: A command write or a buffer write while `busy` is high is ignored. This holds even when it lands in the same cycle as the engine's done pulse for the last phase: interrupt bits already set are kept and no extra phase runs.
- R3: Command bits are `cmd_bits[0]` start, `[1]` transmit, `[2]` receive, `[3]` receive-last and `[4]` stop. The phases run in the order start, transmit, receive (bits 2 and 3 together form one phase), stop. `pend_q` is 0 whenever `busy` is low.
- R4: On start, the state field becomes 4'hA (repeated start) if bit 3 of the current state is set, and 4'h9 (start) otherwise. The buffer value (address in bits 7:1, direction in bit 0) is presented on `eng_wdata`.
- R5: If the address is acknowledged, the state becomes 4'h8 (active). If it is not acknowledged, `irq_q[1]` (TX NAK) is set, every remaining phase of the command is dropped, and the state keeps its start code.
- R6: During transmit the state is 4'hB. An ACK sets `irq_q[0]`. A NAK sets `irq_q[1]` only (never `irq_q[3]`) and drops the receive phase. Either way the state then returns to 4'h8.
- R7: During receive the state is 4'hC. The operation is READ, or READ_NACK when bit 3 is set. The received byte goes into the buffer, or 8'hFF if the engine reports a failed read. The state then returns to 4'h8.
- R8: A stop while state bit 3 is clear sets `irq_q[3]` (abnormal), issues no engine operation and sets the state to 4'h0.
- R9: A legal stop shows state 4'h4 while the engine's STOP runs. It then sets `irq_q[2]` (normal stop) and sets the state to 4'h0.
- R10: `eng_req` is a one-cycle pulse with `eng_op` coded as 0 START_ADDR, 1 WRITE, 2 READ, 3 READ_NACK, 4 STOP. At most one operation is outstanding, and none is issued while idle.
- R11: After reset, `busy`, `pend_q`, `state_q`, `irq_q`, `eng_req` and `buf_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_bits | input | 5 | Requested phases: start, transmit, receive, receive-last, stop |
| buf_wr | input | 1 | Data buffer write strobe |
| buf_wdata | input | DATA_W | Data buffer write value |
| buf_q | output | DATA_W | Data buffer contents (address/transmit byte or received byte) |
| busy | output | 1 | Command in progress |
| pend_q | output | 5 | Command bits not yet completed |
| state_q | output | 4 | State field; bit 3 is the bus-owned flag |
| irq_q | output | 4 | Interrupt status: TX ACK, TX NAK, normal stop, abnormal stop |
| eng_req | output | 1 | One-cycle operation request to the bit engine |
| eng_op | output | 3 | Requested operation code |
| eng_wdata | output | DATA_W | Byte for START_ADDR or WRITE |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_ack | input | 1 | Slave ACK for address/write; read success for reads |
| eng_rdata | input | DATA_W | Byte received by the engine |

## Verification
Two things can fall in the same cycle: the engine's done pulse for the final phase of a command, and a new software command write. The bench provokes this by driving the engine by hand. It raises done with a NAK on the transmit phase and, in that same cycle, presents a stop-only command. It then also tries a buffer write while the sequencer is between phases. The result is judged at the ports:
- `irq_q` must show exactly the TX NAK bit, with no abnormal or normal-stop bit.
- The state must remain active.
- The buffer must be unchanged.
- Exactly two engine operations must have been issued.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;

    localparam int STATE_W = 4;
    localparam int CMD_W   = 5;
    localparam int IRQ_W   = 4;
    localparam int NPH     = 4;
    localparam int OP_W    = 3;

    // command bit positions
    localparam int CB_START = 0;
    localparam int CB_TX    = 1;
    localparam int CB_RX    = 2;
    localparam int CB_RXL   = 3;
    localparam int CB_STOP  = 4;

    // phase slots in priority order
    localparam int PH_START = 0;
    localparam int PH_TX    = 1;
    localparam int PH_RX    = 2;
    localparam int PH_STOP  = 3;

    // interrupt bit positions
    localparam int IB_TX_ACK = 0;
    localparam int IB_TX_NAK = 1;
    localparam int IB_STOP   = 2;
    localparam int IB_ABN    = 3;

    // state field codes; bit ACT_BIT marks bus ownership
    localparam int ACT_BIT = 3;
    localparam logic [STATE_W-1:0] ST_IDLE   = 4'h0;
    localparam logic [STATE_W-1:0] ST_STOP   = 4'h4;
    localparam logic [STATE_W-1:0] ST_ACTIVE = 4'h8;
    localparam logic [STATE_W-1:0] ST_START  = 4'h9;
    localparam logic [STATE_W-1:0] ST_RSTART = 4'hA;
    localparam logic [STATE_W-1:0] ST_TXD    = 4'hB;
    localparam logic [STATE_W-1:0] ST_RXD    = 4'hC;

    typedef enum logic [OP_W-1:0] {
        OP_START_ADDR = 3'd0,
        OP_WRITE      = 3'd1,
        OP_READ       = 3'd2,
        OP_READ_NACK  = 3'd3,
        OP_STOP       = 3'd4
    } eng_op_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PICK,
        SEQ_WAIT_ADDR,
        SEQ_WAIT_TX,
        SEQ_WAIT_RX,
        SEQ_WAIT_STOP
    } seq_e;

endpackage

// File: rtl/i2cseq_phase_pick.sv
`timescale 1ns/1ps
module i2cseq_phase_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    assign any = |req;

    // lowest index wins
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

endmodule

// File: rtl/i2cseq_irq.sv
`timescale 1ns/1ps
module i2cseq_irq #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else begin
            q <= q | set;
        end
    end

endmodule

// File: rtl/i2cseq_databuf.sv
`timescale 1ns/1ps
module i2cseq_databuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_we,
    input  logic [W-1:0] sw_d,
    input  logic         rx_we,
    input  logic [W-1:0] rx_d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (rx_we) begin
            q <= rx_d;
        end else if (sw_we) begin
            q <= sw_d;
        end
    end

endmodule

// File: rtl/i2c_cmd_sequencer.sv
`timescale 1ns/1ps
module i2c_cmd_sequencer
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_bits,
    input  logic                buf_wr,
    input  logic [DATA_W-1:0]   buf_wdata,
    output logic [DATA_W-1:0]   buf_q,
    output logic                busy,
    output logic [CMD_W-1:0]    pend_q,
    output logic [STATE_W-1:0]  state_q,
    output logic [IRQ_W-1:0]    irq_q,
    output logic                eng_req,
    output logic [OP_W-1:0]     eng_op,
    output logic [DATA_W-1:0]   eng_wdata,
    input  logic                eng_done,
    input  logic                eng_ack,
    input  logic [DATA_W-1:0]   eng_rdata
);

    seq_e                seq_q, seq_d;
    logic [CMD_W-1:0]    pend_d;
    logic [STATE_W-1:0]  state_d;
    logic                req_d;
    eng_op_e             op_q, op_d;
    logic [IRQ_W-1:0]    irq_set;
    logic                irq_clr;
    logic                rx_we;
    logic [DATA_W-1:0]   rx_d;
    logic [NPH-1:0]      ph_req;
    logic [NPH-1:0]      ph_grant;
    logic                ph_any;

    // receive and receive-last share one phase slot
    assign ph_req[PH_START] = pend_q[CB_START];
    assign ph_req[PH_TX]    = pend_q[CB_TX];
    assign ph_req[PH_RX]    = pend_q[CB_RX] | pend_q[CB_RXL];
    assign ph_req[PH_STOP]  = pend_q[CB_STOP];

    i2cseq_phase_pick #(.N(NPH)) u_pick (
        .req   (ph_req),
        .grant (ph_grant),
        .any   (ph_any)
    );

    i2cseq_irq #(.W(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (irq_clr),
        .set   (irq_set),
        .q     (irq_q)
    );

    i2cseq_databuf #(.W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_we (buf_wr && !busy),
        .sw_d  (buf_wdata),
        .rx_we (rx_we),
        .rx_d  (rx_d),
        .q     (buf_q)
    );

    assign busy      = (seq_q != SEQ_IDLE);
    assign eng_op    = op_q;
    assign eng_wdata = buf_q;

    // next-state and phase bookkeeping
    always_comb begin
        seq_d   = seq_q;
        pend_d  = pend_q;
        state_d = state_q;
        req_d   = 1'b0;
        op_d    = op_q;
        irq_set = '0;
        irq_clr = 1'b0;
        rx_we   = 1'b0;
        rx_d    = eng_rdata;
        unique case (seq_q)
            SEQ_IDLE: begin
                if (cmd_wr) begin
                    pend_d  = cmd_bits;
                    irq_clr = 1'b1;
                    seq_d   = SEQ_PICK;
                end
            end
            SEQ_PICK: begin
                if (!ph_any) begin
                    seq_d = SEQ_IDLE;
                end else if (ph_grant[PH_START]) begin
                    state_d = state_q[ACT_BIT] ? ST_RSTART : ST_START;
                    req_d   = 1'b1;
                    op_d    = OP_START_ADDR;
                    seq_d   = SEQ_WAIT_ADDR;
                end else if (ph_grant[PH_TX]) begin
                    state_d = ST_TXD;
                    req_d   = 1'b1;
                    op_d    = OP_WRITE;
                    seq_d   = SEQ_WAIT_TX;
                end else if (ph_grant[PH_RX]) begin
                    state_d = ST_RXD;
                    req_d   = 1'b1;
                    op_d    = pend_q[CB_RXL] ? OP_READ_NACK : OP_READ;
                    seq_d   = SEQ_WAIT_RX;
                end else if (ph_grant[PH_STOP]) begin
                    if (state_q[ACT_BIT]) begin
                        state_d = ST_STOP;
                        req_d   = 1'b1;
                        op_d    = OP_STOP;
                        seq_d   = SEQ_WAIT_STOP;
                    end else begin
                        irq_set[IB_ABN] = 1'b1;
                        pend_d[CB_STOP] = 1'b0;
                        state_d         = ST_IDLE;
                        seq_d           = SEQ_PICK;
                    end
                end
            end
            SEQ_WAIT_ADDR: begin
                if (eng_done) begin
                    pend_d[CB_START] = 1'b0;
                    if (eng_ack) begin
                        state_d = ST_ACTIVE;
                    end else begin
                        irq_set[IB_TX_NAK] = 1'b1;
                        pend_d             = '0;
                    end
                    seq_d = SEQ_PICK;
                end
            end
            SEQ_WAIT_TX: begin
                if (eng_done) begin
                    pend_d[CB_TX] = 1'b0;
                    state_d       = ST_ACTIVE;
                    if (eng_ack) begin
                        irq_set[IB_TX_ACK] = 1'b1;
                    end else begin
                        irq_set[IB_TX_NAK] = 1'b1;
                        pend_d[CB_RX]      = 1'b0;
                        pend_d[CB_RXL]     = 1'b0;
                    end
                    seq_d = SEQ_PICK;
                end
            end
            SEQ_WAIT_RX: begin
                if (eng_done) begin
                    pend_d[CB_RX]  = 1'b0;
                    pend_d[CB_RXL] = 1'b0;
                    rx_we          = 1'b1;
                    rx_d           = eng_ack ? eng_rdata : '1;
                    state_d        = ST_ACTIVE;
                    seq_d          = SEQ_PICK;
                end
            end
            SEQ_WAIT_STOP: begin
                if (eng_done) begin
                    pend_d[CB_STOP]  = 1'b0;
                    irq_set[IB_STOP] = 1'b1;
                    state_d          = ST_IDLE;
                    seq_d            = SEQ_PICK;
                end
            end
            default: begin
                seq_d = SEQ_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            state_q <= ST_IDLE;
            eng_req <= 1'b0;
            op_q    <= OP_START_ADDR;
        end else begin
            pend_q  <= pend_d;
            state_q <= state_d;
            eng_req <= req_d;
            op_q    <= op_d;
        end
    end

endmodule

// File: rtl/i2cseq_checker.sv
`timescale 1ns/1ps
module i2cseq_checker
    import i2cseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_wr,
    input logic               buf_wr,
    input logic               eng_done,
    input logic               busy,
    input logic [CMD_W-1:0]   pend_q,
    input logic [STATE_W-1:0] state_q,
    input logic [IRQ_W-1:0]   irq_q,
    input logic               eng_req,
    input logic [OP_W-1:0]    eng_op,
    input logic [DATA_W-1:0]  buf_q
);

    assert_wr_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr) |=> (irq_q == '0 && busy));

    assert_busy_cmd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ((irq_q & $past(irq_q)) == $past(irq_q)));

    assert_busy_buf_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf_wr && !eng_done) |=> (buf_q == $past(buf_q)));

    assert_idle_no_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pend_q == '0));

    assert_start_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 3'(OP_START_ADDR)) |->
            (state_q == ($past(state_q[ACT_BIT]) ? ST_RSTART : ST_START)));

    assert_ack_nak_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q[IB_TX_ACK] && irq_q[IB_TX_NAK]));

    assert_abnormal_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[IB_ABN] |-> (state_q == ST_IDLE && !irq_q[IB_STOP]));

    assert_stop_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_op == 3'(OP_STOP)) |-> ($past(state_q[ACT_BIT]) && state_q == ST_STOP));

    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req);

endmodule

bind i2c_cmd_sequencer i2cseq_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .buf_wr   (buf_wr),
    .eng_done (eng_done),
    .busy     (busy),
    .pend_q   (pend_q),
    .state_q  (state_q),
    .irq_q    (irq_q),
    .eng_req  (eng_req),
    .eng_op   (eng_op),
    .buf_q    (buf_q)
);

// File: tb/i2c_cmd_sequencer_test.sv
`timescale 1ns/1ps
module i2c_cmd_sequencer_test;

    localparam int NV       = 11;
    localparam int WD_LIMIT = 20000;

    typedef struct packed {
        logic [4:0]  cmd;
        logic [7:0]  bufv;
        logic        a_ack;
        logic        t_ack;
        logic        r_ok;
        logic [7:0]  rdat;
        logic [3:0]  e_irq;
        logic [3:0]  e_state;
        logic [7:0]  e_buf;
        logic [2:0]  e_n;
        logic [11:0] e_ops;
        logic [3:0]  e_st0;
    } vec_t;

    // ops packed: first op in [2:0]; codes 0 START_ADDR 1 WRITE 2 READ 3 READ_NACK 4 STOP
    localparam vec_t VECS [NV] = '{
        '{5'h10, 8'h55, 1'b1, 1'b1, 1'b1, 8'h00, 4'h8, 4'h0, 8'h55, 3'd0, 12'h000, 4'h0},
        '{5'h03, 8'hA0, 1'b1, 1'b1, 1'b1, 8'h00, 4'h1, 4'h8, 8'hA0, 3'd2, 12'h008, 4'h9},
        '{5'h02, 8'h3C, 1'b1, 1'b0, 1'b1, 8'h00, 4'h2, 4'h8, 8'h3C, 3'd1, 12'h001, 4'hB},
        '{5'h01, 8'hA1, 1'b1, 1'b1, 1'b1, 8'h00, 4'h0, 4'h8, 8'hA1, 3'd1, 12'h000, 4'hA},
        '{5'h18, 8'h77, 1'b1, 1'b1, 1'b1, 8'h5A, 4'h4, 4'h0, 8'h5A, 3'd2, 12'h023, 4'hC},
        '{5'h15, 8'hA1, 1'b1, 1'b1, 1'b0, 8'h33, 4'h4, 4'h0, 8'hFF, 3'd3, 12'h110, 4'h9},
        '{5'h17, 8'hB0, 1'b0, 1'b1, 1'b1, 8'h00, 4'h2, 4'h9, 8'hB0, 3'd1, 12'h000, 4'h9},
        '{5'h10, 8'h66, 1'b1, 1'b1, 1'b1, 8'h00, 4'h4, 4'h0, 8'h66, 3'd1, 12'h004, 4'h4},
        '{5'h17, 8'hC2, 1'b1, 1'b0, 1'b1, 8'h99, 4'h6, 4'h0, 8'hC2, 3'd3, 12'h108, 4'h9},
        '{5'h0C, 8'h12, 1'b1, 1'b1, 1'b1, 8'h11, 4'h0, 4'h8, 8'h11, 3'd1, 12'h003, 4'hC},
        '{5'h10, 8'h34, 1'b1, 1'b1, 1'b1, 8'h00, 4'h4, 4'h0, 8'h34, 3'd1, 12'h004, 4'h4}
    };

    function automatic string vtag(input int i);
        case (i)
            0:       return "R8";
            1:       return "R4 R6";
            2:       return "R6";
            3:       return "R4 R5";
            4:       return "R7 R9";
            5:       return "R3 R7";
            6:       return "R5";
            7:       return "R9";
            8:       return "R3 R6";
            9:       return "R7";
            default: return "R9";
        endcase
    endfunction

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [4:0] cmd_bits = '0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_q;
    logic       busy;
    logic [4:0] pend_q;
    logic [3:0] state_q;
    logic [3:0] irq_q;
    logic       eng_req;
    logic [2:0] eng_op;
    logic [7:0] eng_wdata;
    logic       eng_done;
    logic       eng_ack;
    logic [7:0] eng_rdata;

    // engine model controls
    logic       manual = 1'b0;
    logic       man_done = 1'b0;
    logic       man_ack = 1'b0;
    logic       auto_done = 1'b0;
    logic       auto_ack = 1'b0;
    logic [7:0] auto_rd = '0;
    logic       cfg_aack = 1'b1;
    logic       cfg_tack = 1'b1;
    logic       cfg_rok = 1'b1;
    logic [7:0] cfg_rdat = '0;
    int         lat = 0;

    // record of issued operations
    logic [2:0] ops   [64];
    logic [3:0] st_at [64];
    logic [7:0] wd_at [64];
    int         nops = 0;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    logic wd_hit = 1'b0;

    assign eng_done  = manual ? man_done : auto_done;
    assign eng_ack   = manual ? man_ack : auto_ack;
    assign eng_rdata = manual ? 8'h00 : auto_rd;

    always #10 clk = ~clk;

    i2c_cmd_sequencer #(.DATA_W(8)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_bits  (cmd_bits),
        .buf_wr    (buf_wr),
        .buf_wdata (buf_wdata),
        .buf_q     (buf_q),
        .busy      (busy),
        .pend_q    (pend_q),
        .state_q   (state_q),
        .irq_q     (irq_q),
        .eng_req   (eng_req),
        .eng_op    (eng_op),
        .eng_wdata (eng_wdata),
        .eng_done  (eng_done),
        .eng_ack   (eng_ack),
        .eng_rdata (eng_rdata)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > WD_LIMIT) wd_hit = 1'b1;
    end

    // bit-engine model
    logic       waiting = 1'b0;
    int         cnt = 0;
    logic [2:0] pend_op = '0;
    always @(negedge clk) begin
        auto_done = 1'b0;
        if (eng_req) begin
            if (nops < 64) begin
                ops[nops]   = eng_op;
                st_at[nops] = state_q;
                wd_at[nops] = eng_wdata;
                nops = nops + 1;
            end
            if (!manual) begin
                pend_op = eng_op;
                cnt     = lat;
                waiting = 1'b1;
            end
        end else if (waiting) begin
            if (cnt == 0) begin
                auto_done = 1'b1;
                waiting   = 1'b0;
                auto_rd   = cfg_rdat;
                case (pend_op)
                    3'd0:    auto_ack = cfg_aack;
                    3'd1:    auto_ack = cfg_tack;
                    3'd2,
                    3'd3:    auto_ack = cfg_rok;
                    default: auto_ack = 1'b1;
                endcase
            end else begin
                cnt = cnt - 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [4:0] c, input logic [7:0] b);
        @(negedge clk);
        buf_wr    = 1'b1;
        buf_wdata = b;
        @(negedge clk);
        buf_wr   = 1'b0;
        cmd_wr   = 1'b1;
        cmd_bits = c;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R1 busy after command write", busy, 1);
    endtask

    task automatic wait_idle();
        while (busy && !wd_hit) @(negedge clk);
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!eng_req && !wd_hit);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // reset state
        chk("R11 busy", busy, 0);
        chk("R11 state", state_q, 0);
        chk("R11 irq", irq_q, 0);
        chk("R11 pend", pend_q, 0);
        chk("R11 eng_req", eng_req, 0);
        chk("R11 buf", buf_q, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cfg_aack = VECS[i].a_ack;
            cfg_tack = VECS[i].t_ack;
            cfg_rok  = VECS[i].r_ok;
            cfg_rdat = VECS[i].rdat;
            lat      = i % 3;
            base     = nops;
            issue_cmd(VECS[i].cmd, VECS[i].bufv);
            wait_idle();
            chk({vtag(i), " irq"}, irq_q, VECS[i].e_irq);
            chk({vtag(i), " state"}, state_q, VECS[i].e_state);
            chk({vtag(i), " buffer"}, buf_q, VECS[i].e_buf);
            chk("R3 pending cleared", pend_q, 0);
            chk("R10 op count", nops - base, VECS[i].e_n);
            for (int k = 0; k < 4; k++) begin
                if (k < int'(VECS[i].e_n)) begin
                    chk("R3 R10 op order", ops[base + k], VECS[i].e_ops[3*k +: 3]);
                end
            end
            if (VECS[i].e_n != 0) begin
                chk({vtag(i), " state at first op"}, st_at[base], VECS[i].e_st0);
                chk("R4 eng_wdata from buffer", wd_at[base], VECS[i].bufv);
            end
        end

        // collision: last done pulse together with a new command write
        manual = 1'b1;
        base   = nops;
        issue_cmd(5'h03, 8'h42);
        wait_req();
        @(negedge clk);
        man_done = 1'b1;
        man_ack  = 1'b1;
        @(negedge clk);
        man_done  = 1'b0;
        buf_wr    = 1'b1;
        buf_wdata = 8'hEE;
        @(negedge clk);
        buf_wr = 1'b0;
        while (!eng_req && !wd_hit) @(negedge clk);
        chk("R2 transmit issued", eng_op, 1);
        @(negedge clk);
        man_done = 1'b1;
        man_ack  = 1'b0;
        cmd_wr   = 1'b1;
        cmd_bits = 5'h10;
        @(negedge clk);
        man_done = 1'b0;
        cmd_wr   = 1'b0;
        wait_idle();
        manual = 1'b0;
        chk("R2 irq kept, write ignored", irq_q, 4'h2);
        chk("R2 state stays active", state_q, 4'h8);
        chk("R2 buffer write ignored", buf_q, 8'h42);
        chk("R2 no extra op", nops - base, 2);

        // close the bus with a legal stop
        cfg_aack = 1'b1;
        lat      = 1;
        base     = nops;
        issue_cmd(5'h10, 8'h42);
        wait_idle();
        chk("R9 normal stop irq", irq_q, 4'h4);
        chk("R9 idle after stop", state_q, 4'h0);
        chk("R9 stop op", ops[base], 4);

        if (wd_hit) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule